// File: doc/BRIEF.md
# Dual-Master Bus Ownership Controller

This block decides which of two upstream masters drives a shared downstream two-wire bus, and manages every handover between them. Each master writes a six-bit control word holding an ownership code, a recovery-request flag and three interrupt mask bits. The controller drives the select signal of an external pad multiplexer. It can start an external recovery sequencer, and it tells each master about events that concern it. Each master has a sticky, clear-on-read status register and an active-low interrupt line for this.

A handover is requested by a control write. It does not take effect until the requesting master has issued a STOP on its own upstream port, and the downstream bus belongs to nobody until then. If the request asked for recovery, the sequencer runs before the new master is connected, and that master then gets an init-done event. Without recovery, the new master is connected at once. It gets a bus-not-ok event if the downstream bus was busy at that moment. A master that loses the bus gets a bus-lost event.

Top module: `dual_master_switch`

## Requirements
- R1: After reset `sel` is 00 (no master connected), `rec_start` is 0, both status registers read 000 and both interrupt lines are high.
- R2: Control word bit 0 is the ownership bit and bit 1 the inverted-ownership bit. If their XOR is 1, the writer is requested. If it is 0, the other master is requested. `sel` is 01 for master A, 10 for master B and 00 for none, and never has both bits set.
- R3: After an accepted request, `sel` is 00 until the requesting master's STOP strobe. A STOP from the other master has no effect.
- R4: If a request disconnects a connected master, that master's status bit 0 (bus lost) is set. Its interrupt line goes low unless its control bit 3 (bus-lost mask) is 1.
- R5: When control bit 2 (recovery request) was set in the requesting write, the requester's STOP produces a one-cycle `rec_start` pulse. `sel` stays 00 until `rec_done`. The new master is then connected, its status bit 1 (init done) is set, and its interrupt goes low unless control bit 4 is 1.
- R6: Without recovery, the new master is connected on the requester's STOP. If `dn_idle` is 0 at that edge, its status bit 2 (bus not ok) is set and its interrupt goes low unless control bit 5 is 1. If `dn_idle` is 1, no status bit is set.
- R7: A request for the master already connected changes nothing: no disconnect, no status bit, no interrupt.
- R8: Status bits are sticky, are visible while the read strobe is high, and are zero in the cycle after a read.
- R9: A new request while a handover waits for STOP replaces the pending one, including its requester.
- R10: When both masters write in the same cycle, master A's request is taken (parameter `A_WINS` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Master A control write strobe |
| a_wdata | input | 6 | Master A control word |
| a_rd | input | 1 | Master A status read strobe (clears status) |
| a_stat | output | 3 | Master A status: {bus not ok, init done, bus lost} |
| b_wr | input | 1 | Master B control write strobe |
| b_wdata | input | 6 | Master B control word |
| b_rd | input | 1 | Master B status read strobe (clears status) |
| b_stat | output | 3 | Master B status: {bus not ok, init done, bus lost} |
| stop_a | input | 1 | STOP detected on master A's upstream port |
| stop_b | input | 1 | STOP detected on master B's upstream port |
| dn_idle | input | 1 | Downstream bus is idle |
| rec_done | input | 1 | Recovery sequencer finished |
| sel | output | 2 | Pad mux select: 00 none, 01 A, 10 B |
| rec_start | output | 1 | One-cycle pulse that starts recovery |
| irq_n_a | output | 1 | Master A interrupt, active low |
| irq_n_b | output | 1 | Master B interrupt, active low |

## Verification
The bench uses the default `A_WINS` = 1, so simultaneous writes resolve in master A's favour, and it tests that order directly. A vector table walks a chain of ownership codes from both masters. This covers both code polarities, requests for the current owner, and busy and idle switch points. Directed cases then cover masks, a STOP from the wrong master, recovery with a late done, and a pending request being replaced.

// File: rtl/dual_master_switch.sv
module dual_master_switch #(
  parameter bit A_WINS = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_wr,
  input  logic [5:0] a_wdata,
  input  logic       a_rd,
  output logic [2:0] a_stat,
  input  logic       b_wr,
  input  logic [5:0] b_wdata,
  input  logic       b_rd,
  output logic [2:0] b_stat,
  input  logic       stop_a,
  input  logic       stop_b,
  input  logic       dn_idle,
  input  logic       rec_done,
  output logic [1:0] sel,
  output logic       rec_start,
  output logic       irq_n_a,
  output logic       irq_n_b
);
  localparam logic [1:0] SEL_A = 2'b01;
  localparam logic [1:0] SEL_B = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REC} state_t;

  state_t     state;
  logic [1:0] pend;
  logic       req_b, init_q;
  logic [2:0] msk_a, msk_b;

  logic       use_a, use_b, take, stop_req, conn, go_rec, rec_fin;
  logic [1:0] a_tgt, b_tgt, w_tgt;
  logic [2:0] set_a, set_b;

  assign a_tgt = (a_wdata[0] ^ a_wdata[1]) ? SEL_A : SEL_B;
  assign b_tgt = (b_wdata[0] ^ b_wdata[1]) ? SEL_B : SEL_A;
  assign use_a = a_wr && (A_WINS || !b_wr);
  assign use_b = b_wr && !use_a;
  assign w_tgt = use_a ? a_tgt : b_tgt;

  assign take     = (use_a || use_b) && state != S_REC && (state == S_WAIT || w_tgt != sel);
  assign stop_req = req_b ? stop_b : stop_a;
  assign conn     = state == S_WAIT && stop_req && !init_q && !take;
  assign go_rec   = state == S_WAIT && stop_req && init_q && !take;
  assign rec_fin  = state == S_REC && rec_done;

  assign set_a = {conn && pend == SEL_A && !dn_idle, rec_fin && pend == SEL_A,
                  take && state == S_IDLE && sel == SEL_A};
  assign set_b = {conn && pend == SEL_B && !dn_idle, rec_fin && pend == SEL_B,
                  take && state == S_IDLE && sel == SEL_B};

  assign irq_n_a = ~|(a_stat & ~msk_a);
  assign irq_n_b = ~|(b_stat & ~msk_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sel       <= 2'b00;
      pend      <= 2'b00;
      req_b     <= 1'b0;
      init_q    <= 1'b0;
      rec_start <= 1'b0;
    end else begin
      rec_start <= go_rec;
      if (take) begin
        state  <= S_WAIT;
        sel    <= 2'b00;
        pend   <= w_tgt;
        req_b  <= use_b;
        init_q <= use_a ? a_wdata[2] : b_wdata[2];
      end else if (conn || rec_fin) begin
        state <= S_IDLE;
        sel   <= pend;
      end else if (go_rec) begin
        state <= S_REC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_a  <= '0;
      msk_b  <= '0;
      a_stat <= '0;
      b_stat <= '0;
    end else begin
      if (a_wr) msk_a <= a_wdata[5:3];
      if (b_wr) msk_b <= b_wdata[5:3];
      a_stat <= (a_rd ? 3'b000 : a_stat) | set_a;
      b_stat <= (b_rd ? 3'b000 : b_stat) | set_b;
    end
  end

  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R2
  AST_NONE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (sel == 2'b00)); // R3
  AST_CONNECT_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == 2'b00 && sel != 2'b00) |-> $past(stop_a || stop_b || rec_done)); // R3
  AST_REC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_start |=> !rec_start); // R5
  AST_LOST_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_stat[0]) |-> $past(a_wr || b_wr)); // R4
  AST_LOST_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_stat[0]) |-> $past(a_wr || b_wr)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && set_a == 3'b000) |=> (a_stat == 3'b000)); // R8
endmodule

// File: tb/tb_dual_master_switch.sv
module tb_dual_master_switch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_wr = 0, b_wr = 0, a_rd = 0, b_rd = 0;
  logic [5:0] a_wdata = '0, b_wdata = '0;
  logic       stop_a = 0, stop_b = 0, dn_idle = 1, rec_done = 0;
  logic [2:0] a_stat, b_stat;
  logic [1:0] sel;
  logic       rec_start, irq_n_a, irq_n_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_master_switch #(.A_WINS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_wdata(a_wdata), .a_rd(a_rd), .a_stat(a_stat),
    .b_wr(b_wr), .b_wdata(b_wdata), .b_rd(b_rd), .b_stat(b_stat),
    .stop_a(stop_a), .stop_b(stop_b), .dn_idle(dn_idle), .rec_done(rec_done),
    .sel(sel), .rec_start(rec_start), .irq_n_a(irq_n_a), .irq_n_b(irq_n_b)
  );

  // {master, own, nown, idle, exp_sel[1:0], exp_a_stat[2:0], exp_b_stat[2:0]}
  localparam logic [11:0] VEC [6] = '{
    12'b0_1_0_1_01_000_000,
    12'b1_0_1_0_10_001_100,
    12'b0_1_1_1_10_000_000,
    12'b1_0_0_1_01_000_001,
    12'b0_0_0_0_10_001_100,
    12'b1_1_0_0_10_000_000
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit m, input logic [5:0] d);
    @(negedge clk);
    if (!m) begin a_wr = 1; a_wdata = d; end
    else    begin b_wr = 1; b_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic stp(input bit m);
    if (!m) stop_a = 1; else stop_b = 1;
    @(negedge clk);
    stop_a = 0; stop_b = 0;
  endtask

  task automatic rd_both();
    a_rd = 1; b_rd = 1;
    @(negedge clk);
    a_rd = 0; b_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 sel", {6'd0, sel}, 8'h0);
    chk("R1 rec_start", {7'd0, rec_start}, 8'h0);
    chk("R1 stat", {2'd0, a_stat, b_stat}, 8'h0);
    chk("R1 irq", {6'd0, irq_n_a, irq_n_b}, 8'h3);
    rst_n = 1;

    foreach (VEC[i]) begin
      wr(VEC[i][11], {4'b0000, VEC[i][9], VEC[i][10]});
      dn_idle = VEC[i][8];
      stp(VEC[i][11]);
      chk("R2 R7 vector sel", {6'd0, sel}, {6'd0, VEC[i][7:6]});
      chk("R4 R6 vector stat", {2'd0, a_stat, b_stat}, {2'd0, VEC[i][5:0]});
      chk("R4 R6 vector irq", {6'd0, irq_n_a, irq_n_b},
          {6'd0, VEC[i][5:3] == 3'b000, VEC[i][2:0] == 3'b000});
      rd_both();
      chk("R8 cleared after read", {2'd0, a_stat, b_stat}, 8'h0);
    end

    // owner B; A requests itself with bus-lost mask set
    wr(0, 6'b001001);
    chk("R4 B lost irq", {7'd0, irq_n_b}, 8'h0);
    chk("R3 none while pending", {6'd0, sel}, 8'h0);
    stp(1);
    chk("R3 other STOP ignored", {6'd0, sel}, 8'h0);
    dn_idle = 1;
    stp(0);
    chk("R3 connect on requester STOP", {6'd0, sel}, 8'h1);
    rd_both();

    // B requests itself with recovery; A lost but masked
    wr(1, 6'b000101);
    chk("R4 A lost masked stat", {5'd0, a_stat}, 8'h1);
    chk("R4 A lost masked irq", {7'd0, irq_n_a}, 8'h1);
    stp(1);
    chk("R5 rec_start pulse", {7'd0, rec_start}, 8'h1);
    chk("R5 none during recovery", {6'd0, sel}, 8'h0);
    @(negedge clk);
    chk("R5 rec_start one cycle", {7'd0, rec_start}, 8'h0);
    @(negedge clk);
    chk("R5 waits for done", {6'd0, sel}, 8'h0);
    rec_done = 1;
    @(negedge clk);
    rec_done = 0;
    chk("R5 connect after done", {6'd0, sel}, 8'h2);
    chk("R5 init done stat", {5'd0, b_stat}, 8'h2);
    chk("R5 init done irq", {7'd0, irq_n_b}, 8'h0);
    rd_both();

    // pending request replaced
    wr(0, 6'b000001);
    wr(1, 6'b000001);
    stp(0);
    chk("R9 replaced requester STOP ignored", {6'd0, sel}, 8'h0);
    dn_idle = 1;
    stp(1);
    chk("R9 new request wins", {6'd0, sel}, 8'h2);
    chk("R9 B lost from first request", {5'd0, b_stat}, 8'h1);
    rd_both();

    // simultaneous writes
    @(negedge clk);
    a_wr = 1; a_wdata = 6'b000001;
    b_wr = 1; b_wdata = 6'b000001;
    @(negedge clk);
    a_wr = 0; b_wr = 0;
    stp(0);
    chk("R10 A wins tie", {6'd0, sel}, 8'h1);
    chk("R10 B lost", {5'd0, b_stat}, 8'h1);
    rd_both();

    // busy switch with bus-not-ok masked
    wr(1, 6'b100001);
    chk("R4 A lost unmasked irq", {7'd0, irq_n_a}, 8'h0);
    dn_idle = 0;
    stp(1);
    chk("R6 connect busy", {6'd0, sel}, 8'h2);
    chk("R6 busnok stat", {5'd0, b_stat}, 8'h4);
    chk("R6 busnok masked irq", {7'd0, irq_n_b}, 8'h1);
    chk("R8 sticky before read", {5'd0, a_stat}, 8'h1);
    rd_both();
    chk("R8 cleared", {2'd0, a_stat, b_stat}, 8'h0);
    chk("R8 irq released", {6'd0, irq_n_a, irq_n_b}, 8'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule